// File: doc/BRIEF.md
# Vector Length Context Register

This block keeps the loop context of a parallel execution unit in one 32-bit word. The word holds the maximum vector length, the current vector length, the sub-vector group size, the source and destination element offsets and the sub-vector destination offset. A CSR-style request port reads or overwrites the word, sets the vector length, sets the maximum vector length, or sets the group size. Every accepted request returns, one cycle later, the value that actually took effect. Because a request may be clamped, this value can differ from the one asked for.

Both lengths are stored minus one. A stored 0 therefore means a length of 1, and the full range 1 to XLEN fits in six bits. Length requests come in two forms. The register form carries the length itself. The immediate form carries the length minus one in its low five bits.

On a trap-entry or trap-return strobe, the live word is exchanged with the saved copy that belongs to the privilege level on `priv_sel_i`.

Top module: `vlctx_state_reg`

## Requirements
- R1: After reset the context word reads 0 (both lengths 1, group size 1, all offsets 0), every saved copy is 0, and `rsp_valid_o` is low.
- R2: The context word packs its fields as follows. Bits 5:0 hold the maximum length minus one. Bits 11:6 hold the length minus one. Bits 17:12 hold the source offset and bits 23:18 the destination offset. Bits 25:24 hold the group size minus one and bits 27:26 the sub-vector offset. A read (op 0) returns this word unchanged.
- R3: Set-length (op 2) stores MIN(request, maximum length), raises a request of 0 to 1, and returns the stored length, not its encoding.
- R4: When `req_imm_i` is high, a length request (op 2 or op 3) uses `req_data_i[4:0] + 1` as its request and ignores the upper data bits.
- R5: Set-maximum (op 3) clamps the request to the range 1..XLEN and returns the stored length. If the current length exceeds the new maximum, the length is cut down to it.
- R6: Write (op 1) stores the data word with these changes: bits 31:28 are forced to 0, the maximum field is capped at XLEN-1, and the length field is capped at the stored maximum field. All other fields are kept as written. The response is the stored word.
- R7: Set-group (op 4) with data 1..4 stores data-1 in bits 25:24 and returns the data. Any other value sets `rsp_illegal_o`, returns 0 and leaves the word unchanged.
- R8: Op codes 5, 6 and 7 set `rsp_illegal_o` and leave the word unchanged.
- R9: When `trap_enter_i` or `trap_return_i` is high, the live word and the saved copy selected by `priv_sel_i` are exchanged. A request in the same cycle is dropped and produces no response.
- R10: An accepted request produces `rsp_valid_o` for exactly one cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | 0 read, 1 write, 2 set length, 3 set maximum, 4 set group, 5-7 illegal |
| req_imm_i | input | 1 | Immediate form for length requests |
| req_data_i | input | 32 | Request operand |
| trap_enter_i | input | 1 | Swap strobe on trap entry |
| trap_return_i | input | 1 | Swap strobe on trap return |
| priv_sel_i | input | 2 | Privilege level whose saved copy is swapped |
| ctx_o | output | 32 | Live context word |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_data_o | output | 32 | Value that took effect |
| rsp_illegal_o | output | 1 | Request rejected |

## Verification
The length clamps are swept over every request from 0 to 40 against maximum lengths of 1, 7 and 32, plus an all-ones request. This separates the zero floor, the pass-through region and the ceiling. The immediate sweep puts ones in the upper data bits, so a design that reads the whole data bus is caught. A second sweep tries every group code from 0 to 7, and a third tries the three spare op codes; both confirm that rejected requests leave the word untouched. Full-word writes use all-ones, a length above the maximum, and a generated series of words, which exercises each cap on its own. Swaps go through two privilege levels in turn, including a request issued in the same cycle as a strobe, so that a design that fails to restore a saved copy, or that acts on the dropped request, shows up.

// File: rtl/vlctx_pkg.sv
package vlctx_pkg;
  localparam int CTX_W = 32;
  localparam int FLD_W = 6;
  localparam int SUB_W = 2;

  typedef struct packed {
    logic [3:0]       rsvd;
    logic [SUB_W-1:0] sub_idx;
    logic [SUB_W-1:0] grp_m1;
    logic [FLD_W-1:0] dst_idx;
    logic [FLD_W-1:0] src_idx;
    logic [FLD_W-1:0] vl_m1;
    logic [FLD_W-1:0] mvl_m1;
  } ctx_t;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_SETVL  = 3'd2,
    OP_SETMVL = 3'd3,
    OP_SETGRP = 3'd4
  } op_e;
endpackage

// File: rtl/vlctx_len_sat.sv
module vlctx_len_sat #(
  parameter int DW    = 32,
  parameter int LW    = 7,
  parameter int IMM_W = 5
) (
  input  logic [DW-1:0] raw_i,
  input  logic          imm_i,
  input  logic [LW-1:0] ceil_i,
  output logic [LW-1:0] len_o
);
  logic [DW:0] req;

  always_comb begin
    if (imm_i) begin
      req = {{(DW+1-IMM_W){1'b0}}, raw_i[IMM_W-1:0]} + {{DW{1'b0}}, 1'b1};
    end else begin
      req = {1'b0, raw_i};
    end
    if (req == '0) begin
      len_o = LW'(1);
    end else if (req > {{(DW+1-LW){1'b0}}, ceil_i}) begin
      len_o = ceil_i;
    end else begin
      len_o = req[LW-1:0];
    end
  end
endmodule

// File: rtl/vlctx_save_bank.sv
module vlctx_save_bank #(
  parameter int NUM = 4,
  parameter int SW  = 2,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [NUM-1:0][DW-1:0] slot_q;
  logic [NUM-1:0][DW-1:0] slot_d;
  logic [NUM-1:0]         slot_en;

  always_comb begin
    for (int k = 0; k < NUM; k++) begin
      slot_en[k] = swap_i && (sel_i == SW'(k));
      slot_d[k]  = slot_en[k] ? wdata_i : slot_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (swap_i) begin
      slot_q <= slot_d;
    end
  end

  assign rdata_o = slot_q[sel_i];
endmodule

// File: rtl/vlctx_state_reg.sv
module vlctx_state_reg
  import vlctx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_PRIV = 4,
  localparam int PRIV_W  = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic              req_imm_i,
  input  logic [CTX_W-1:0]  req_data_i,
  input  logic              trap_enter_i,
  input  logic              trap_return_i,
  input  logic [PRIV_W-1:0] priv_sel_i,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              rsp_valid_o,
  output logic [CTX_W-1:0]  rsp_data_o,
  output logic              rsp_illegal_o
);
  localparam int LEN_W = FLD_W + 1;
  localparam logic [FLD_W-1:0] MVL_TOP = FLD_W'(XLEN - 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(XLEN);

  ctx_t             ctx_q, ctx_d, wr_ctx;
  logic             ctx_en;
  logic             swap;
  logic             req_go;
  logic [CTX_W-1:0] saved_rd;
  logic [LEN_W-1:0] vl_len, mvl_len, vl_ceil;
  logic             rsp_valid_q;
  logic [CTX_W-1:0] rsp_data_q, rsp_data_d;
  logic             rsp_ill_q, rsp_ill_d;

  assign swap    = trap_enter_i | trap_return_i;
  assign req_go  = req_valid_i & ~swap;
  assign ctx_en  = swap | req_go;
  assign vl_ceil = {1'b0, ctx_q.mvl_m1} + LEN_W'(1);

  vlctx_len_sat #(.DW(CTX_W), .LW(LEN_W), .IMM_W(5)) u_vl_sat (
    .raw_i (req_data_i),
    .imm_i (req_imm_i),
    .ceil_i(vl_ceil),
    .len_o (vl_len)
  );

  vlctx_len_sat #(.DW(CTX_W), .LW(LEN_W), .IMM_W(5)) u_mvl_sat (
    .raw_i (req_data_i),
    .imm_i (req_imm_i),
    .ceil_i(LEN_CAP),
    .len_o (mvl_len)
  );

  vlctx_save_bank #(.NUM(NUM_PRIV), .SW(PRIV_W), .DW(CTX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .swap_i (swap),
    .sel_i  (priv_sel_i),
    .wdata_i(ctx_q),
    .rdata_o(saved_rd)
  );

  always_comb begin
    wr_ctx        = ctx_t'(req_data_i);
    wr_ctx.rsvd   = '0;
    if (wr_ctx.mvl_m1 > MVL_TOP) wr_ctx.mvl_m1 = MVL_TOP;
    if (wr_ctx.vl_m1 > wr_ctx.mvl_m1) wr_ctx.vl_m1 = wr_ctx.mvl_m1;
  end

  always_comb begin
    ctx_d      = ctx_q;
    rsp_data_d = '0;
    rsp_ill_d  = 1'b0;
    if (swap) begin
      ctx_d = ctx_t'(saved_rd);
    end else if (req_valid_i) begin
      case (req_op_i)
        OP_READ: rsp_data_d = ctx_q;
        OP_WRITE: begin
          ctx_d      = wr_ctx;
          rsp_data_d = wr_ctx;
        end
        OP_SETVL: begin
          ctx_d.vl_m1 = FLD_W'(vl_len - LEN_W'(1));
          rsp_data_d  = CTX_W'(vl_len);
        end
        OP_SETMVL: begin
          ctx_d.mvl_m1 = FLD_W'(mvl_len - LEN_W'(1));
          if (ctx_q.vl_m1 > ctx_d.mvl_m1) ctx_d.vl_m1 = ctx_d.mvl_m1;
          rsp_data_d = CTX_W'(mvl_len);
        end
        OP_SETGRP: begin
          if (req_data_i >= CTX_W'(1) && req_data_i <= CTX_W'(4)) begin
            ctx_d.grp_m1 = SUB_W'(req_data_i - CTX_W'(1));
            rsp_data_d   = req_data_i;
          end else begin
            rsp_ill_d = 1'b1;
          end
        end
        default: rsp_ill_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (ctx_en) begin
      ctx_q <= ctx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_ill_q   <= 1'b0;
    end else begin
      rsp_valid_q <= req_go;
      rsp_data_q  <= rsp_data_d;
      rsp_ill_q   <= rsp_ill_d & req_go;
    end
  end

  assign ctx_o         = ctx_q;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_data_o    = rsp_data_q;
  assign rsp_illegal_o = rsp_ill_q;
endmodule

// File: rtl/vlctx_state_reg_chk.sv
module vlctx_state_reg_chk #(
  parameter int XLEN   = 32,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic              trap_enter_i,
  input logic              trap_return_i,
  input logic [PRIV_W-1:0] priv_sel_i,
  input logic [31:0]       ctx_o,
  input logic              rsp_valid_o,
  input logic [31:0]       rsp_data_o,
  input logic              rsp_illegal_o
);
  logic unused_sel;
  assign unused_sel = ^priv_sel_i;

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_o[31:28] == 4'd0);

  p_mvl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_o[5:0] <= 6'(XLEN - 1));

  p_vl_in_mvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_o[11:6] <= ctx_o[5:0]);

  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal_o |-> (ctx_o == $past(ctx_o)));

  p_setvl_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && $past(req_op_i) == 3'd2) |->
      (rsp_data_o == {26'd0, ctx_o[11:6]} + 32'd1));

  p_swap_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter_i || trap_return_i) |=> !rsp_valid_o);

  p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !trap_enter_i && !trap_return_i) |=> rsp_valid_o);

  p_rsp_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);
endmodule

bind vlctx_state_reg vlctx_state_reg_chk #(.XLEN(XLEN), .PRIV_W(PRIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .trap_enter_i (trap_enter_i),
  .trap_return_i(trap_return_i),
  .priv_sel_i   (priv_sel_i),
  .ctx_o        (ctx_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_illegal_o(rsp_illegal_o)
);

// File: tb/vlctx_state_reg_tb.sv
`timescale 1ns/1ps
module vlctx_state_reg_tb;
  localparam int XL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = 3'd0;
  logic        req_imm_i = 1'b0;
  logic [31:0] req_data_i = 32'd0;
  logic        trap_enter_i = 1'b0;
  logic        trap_return_i = 1'b0;
  logic [1:0]  priv_sel_i = 2'd0;
  logic [31:0] ctx_o;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        rsp_illegal_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] exp_ctx;
  logic [31:0] exp_saved [4];

  always #2.5 clk = ~clk;

  vlctx_state_reg #(.XLEN(XL), .NUM_PRIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_imm_i(req_imm_i), .req_data_i(req_data_i), .trap_enter_i(trap_enter_i),
    .trap_return_i(trap_return_i), .priv_sel_i(priv_sel_i), .ctx_o(ctx_o),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_illegal_o(rsp_illegal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clamp_len(input longint v, input int ceil);
    if (v == 0) return 1;
    if (v > ceil) return ceil;
    return int'(v);
  endfunction

  function automatic int mvl_of(input logic [31:0] w);
    return int'(w[5:0]) + 1;
  endfunction
  function automatic int vl_of(input logic [31:0] w);
    return int'(w[11:6]) + 1;
  endfunction

  function automatic logic [31:0] with_vl(input logic [31:0] w, input int len);
    logic [31:0] r = w;
    r[11:6] = 6'(len - 1);
    return r;
  endfunction

  function automatic logic [31:0] with_mvl(input logic [31:0] w, input int len);
    logic [31:0] r = w;
    r[5:0] = 6'(len - 1);
    if (vl_of(r) > len) r[11:6] = 6'(len - 1);
    return r;
  endfunction

  function automatic logic [31:0] write_model(input logic [31:0] w);
    int mvl_f = int'(w[5:0]);
    int vl_f  = int'(w[11:6]);
    logic [31:0] r;
    if (mvl_f > XL - 1) mvl_f = XL - 1;
    if (vl_f > mvl_f) vl_f = mvl_f;
    r = {4'd0, w[27:12], 6'(vl_f), 6'(mvl_f)};
    return r;
  endfunction

  task automatic issue(input logic [2:0] op, input logic imm, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_imm_i = imm; req_data_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_imm_i = 1'b0; req_data_i = 32'd0;
  endtask

  task automatic swap(input logic enter, input logic [1:0] lvl, input logic with_req);
    logic [31:0] tmp;
    @(negedge clk);
    trap_enter_i = enter; trap_return_i = ~enter; priv_sel_i = lvl;
    req_valid_i = with_req; req_op_i = 3'd2; req_data_i = 32'd3;
    @(negedge clk);
    trap_enter_i = 1'b0; trap_return_i = 1'b0; req_valid_i = 1'b0; req_data_i = 32'd0;
    tmp = exp_ctx; exp_ctx = exp_saved[lvl]; exp_saved[lvl] = tmp;
    chk("R9 swapped word", ctx_o, exp_ctx);
    chk("R9 no response on swap", {31'd0, rsp_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int exp_len;
    int mvls [3];
    mvls[0] = 1; mvls[1] = 7; mvls[2] = 32;
    for (int k = 0; k < 4; k++) exp_saved[k] = 32'd0;
    exp_ctx = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctx after reset", ctx_o, 32'd0);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid_o}, 32'd0);

    // R2 read returns packed word
    issue(3'd0, 1'b0, 32'hDEAD_BEEF);
    chk("R2 read of reset word", rsp_data_o, 32'd0);
    chk("R10 read response valid", {31'd0, rsp_valid_o}, 32'd1);
    @(negedge clk);
    chk("R10 response lasts one cycle", {31'd0, rsp_valid_o}, 32'd0);

    // R5 set-maximum sweep, with length at 20 beforehand
    for (int v = 0; v <= 40; v++) begin
      issue(3'd3, 1'b0, 32'd32); exp_ctx = with_mvl(exp_ctx, 32);
      issue(3'd2, 1'b0, 32'd20); exp_ctx = with_vl(exp_ctx, 20);
      issue(3'd3, 1'b0, 32'(v));
      exp_len = clamp_len(v, XL);
      exp_ctx = with_mvl(exp_ctx, exp_len);
      chk("R5 set-maximum response", rsp_data_o, 32'(exp_len));
      chk("R5 set-maximum word", ctx_o, exp_ctx);
    end
    issue(3'd3, 1'b0, 32'hFFFF_FFFF); exp_ctx = with_mvl(exp_ctx, XL);
    chk("R5 all-ones maximum", rsp_data_o, 32'(XL));

    // R3 set-length sweep against three maxima
    for (int m = 0; m < 3; m++) begin
      issue(3'd3, 1'b0, 32'(mvls[m])); exp_ctx = with_mvl(exp_ctx, mvls[m]);
      for (int v = 0; v <= 40; v++) begin
        issue(3'd2, 1'b0, 32'(v));
        exp_len = clamp_len(v, mvls[m]);
        exp_ctx = with_vl(exp_ctx, exp_len);
        chk("R3 set-length response", rsp_data_o, 32'(exp_len));
        chk("R3 set-length word", ctx_o, exp_ctx);
      end
      issue(3'd2, 1'b0, 32'hFFFF_FFFF);
      exp_ctx = with_vl(exp_ctx, mvls[m]);
      chk("R3 all-ones length", rsp_data_o, 32'(mvls[m]));
    end

    // R4 immediate forms with junk in upper bits
    for (int i = 0; i < 32; i++) begin
      issue(3'd2, 1'b1, 32'hFFFF_FFE0 | 32'(i));
      exp_ctx = with_vl(exp_ctx, i + 1);
      chk("R4 immediate length", rsp_data_o, 32'(i + 1));
      chk("R4 immediate length word", ctx_o, exp_ctx);
    end
    for (int i = 0; i < 32; i++) begin
      issue(3'd3, 1'b1, 32'h5A5A_5A40 | 32'(i));
      exp_ctx = with_mvl(exp_ctx, i + 1);
      chk("R4 immediate maximum", rsp_data_o, 32'(i + 1));
      chk("R4 immediate maximum word", ctx_o, exp_ctx);
    end

    // R7 group size sweep
    for (int g = 0; g < 8; g++) begin
      issue(3'd4, 1'b0, 32'(g));
      if (g >= 1 && g <= 4) begin
        exp_ctx[25:24] = 2'(g - 1);
        chk("R7 legal group response", rsp_data_o, 32'(g));
        chk("R7 legal group flag", {31'd0, rsp_illegal_o}, 32'd0);
      end else begin
        chk("R7 illegal group flag", {31'd0, rsp_illegal_o}, 32'd1);
        chk("R7 illegal group response", rsp_data_o, 32'd0);
      end
      chk("R7 group word", ctx_o, exp_ctx);
    end

    // R8 spare op codes
    for (int op = 5; op < 8; op++) begin
      issue(3'(op), 1'b0, 32'd2);
      chk("R8 spare op flag", {31'd0, rsp_illegal_o}, 32'd1);
      chk("R8 spare op word unchanged", ctx_o, exp_ctx);
    end

    // R6 full-word writes
    w = 32'hFFFF_FFFF;
    for (int n = 0; n < 24; n++) begin
      if (n == 1) w = 32'h0000_0FC5;
      else if (n == 2) w = 32'hA5A5_A5A5;
      else if (n > 2) w = w * 32'd1103515245 + 32'd12345;
      issue(3'd1, 1'b0, w);
      exp_ctx = write_model(w);
      chk("R6 write response", rsp_data_o, exp_ctx);
      chk("R6 write word", ctx_o, exp_ctx);
      issue(3'd0, 1'b0, 32'd0);
      chk("R2 read after write", rsp_data_o, exp_ctx);
    end

    // R9 swaps across two levels
    issue(3'd1, 1'b0, 32'h0123_4567); exp_ctx = write_model(32'h0123_4567);
    swap(1'b1, 2'd2, 1'b0);
    issue(3'd1, 1'b0, 32'h0ABC_1083); exp_ctx = write_model(32'h0ABC_1083);
    swap(1'b0, 2'd2, 1'b1);
    swap(1'b1, 2'd1, 1'b0);
    swap(1'b0, 2'd1, 1'b0);
    swap(1'b1, 2'd2, 1'b1);
    issue(3'd0, 1'b0, 32'd0);
    chk("R9 read after swaps", rsp_data_o, exp_ctx);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule